// File: doc/BRIEF.md
# Serial Peripheral Target Port with Host Status Handshake

This block lets a local processor exchange 8- or 16-bit words with an external serial master over the common four-wire SPI. The master owns the serial clock and an active-low select. The block shifts one bit in from MOSI and one bit out on MISO in every serial clock cycle, so each frame is full duplex. The host side has an active-low chip select, write and read strobes and two 16-bit data buses. A write fills a transmit holding register. A completed frame leaves its received word in a receive register for the host to read.

Four run-time inputs choose the frame shape: clock idle level, clock phase, bit order and word size. All three serial inputs pass through synchronizers into the system clock domain. The serial clock edges are found there, so the serial clock must run at no more than one eighth of the system clock. A frame is bounded by the select line: one frame per select assertion. Serial clock edges that arrive after the last bit, and before select is released, are ignored.

The host sees level status (transmit holding empty, received word waiting) and one-cycle event pulses. The pulses report an overrun, an underrun, a word fully sent, and a frame cut short by select release.

Top module: `spi_target_port`

## Requirements
- R1: After reset, txReady is 1, rxReady is 0, miso is 0 and rxError, txError, txAck and txNack are all 0.
- R2: All four combinations of cpol (clock idle level) and cpha work. The leading edge is the first edge after the idle level. With cpha=0, the first bit is on miso before the first edge, bits are sampled on leading edges and miso changes on trailing edges. With cpha=1, miso changes on every leading edge except the first, and bits are sampled on trailing edges.
- R3: With lsbFirst=1, bit 0 of the word is sent and received first. With lsbFirst=0, the top bit of the word is sent and received first.
- R4: With wide16=1 a frame has 16 bits. With wide16=0 it has 8 bits: only bits 7:0 of the written word are sent, and the received byte appears on hostRdData[7:0] with hostRdData[15:8] equal to 0.
- R5: A cycle with hostCsN=0 and hostWr=1 stores hostWrData and drives txReady to 0. txReady returns to 1 when a frame start takes the stored word.
- R6: When a frame completes, its word appears on hostRdData and rxReady goes to 1. A cycle with hostCsN=0 and hostRd=1 clears rxReady.
- R7: If a frame completes while rxReady is still 1, rxError pulses for one cycle and the new word replaces the old one.
- R8: If a frame starts while txReady is 1, txError pulses for one cycle and the last written word (all zero after reset) is sent again.
- R9: txAck pulses for one cycle when a frame that carried a host-written word completes. An underrun frame gives no txAck.
- R10: If select is released before the last bit, txNack pulses for one cycle. The partial received word is discarded, so rxReady and hostRdData are unchanged and no txAck is given.
- R11: While ssN is high, serial clock activity has no effect and miso is 0. Host strobes with hostCsN=1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the master |
| ssN | input | 1 | Active-low select from the master |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master, 0 while not selected |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Clock phase: 0 = sample on leading edge, 1 = sample on trailing edge |
| lsbFirst | input | 1 | 1 = least significant bit first |
| wide16 | input | 1 | 1 = 16-bit frames, 0 = 8-bit frames |
| hostCsN | input | 1 | Active-low host chip select |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostWrData | input | 16 | Word to transmit |
| hostRdData | output | 16 | Last received word |
| txReady | output | 1 | Transmit holding register empty |
| rxReady | output | 1 | Received word waiting |
| rxError | output | 1 | One-cycle overrun pulse |
| txError | output | 1 | One-cycle underrun pulse |
| txAck | output | 1 | One-cycle pulse: host word fully sent |
| txNack | output | 1 | One-cycle pulse: frame aborted by select release |

## Verification
The hardest conditions to reach are the two error paths and the abort path. Each needs the host side to be held back while the serial side keeps running. The bench switches off its reading monitor and runs two frames back to back, which reaches the overrun. It starts a frame with no word written, which reaches the underrun. It raises select after five bits of a loaded frame, which reaches the abort. After each of these it checks, at the ports, the pulse counts, the status levels and which word is held. The phase cases depend on the bench's own master model, which samples and drives on the opposite edges for each cpha setting. That model covers all four modes in both bit orders and both widths.

// File: rtl/spi_target_pkg.sv
package spi_target_pkg;

  // Strobes from control to datapath, valid for one system clock.
  typedef struct packed {
    logic writeHold;   // host word into holding register
    logic loadTx;      // frame start: holding -> tx shifter, clear rx shifter
    logic shiftTx;     // advance tx shifter one bit
    logic sampleRx;    // take one bit from mosi
    logic commitRx;    // last bit: publish received word
  } ctlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DONE  = 2'd2
  } frameState_e;

endpackage

// File: rtl/spi_target_sync.sv
module spi_target_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclk,
  input  logic ssN,
  input  logic mosi,
  output logic sclkRise,
  output logic sclkFall,
  output logic ssFall,
  output logic ssRise,
  output logic mosiS
);

  logic [STAGES-1:0] sclkPipe;
  logic [STAGES-1:0] ssPipe;
  logic [STAGES-1:0] mosiPipe;
  logic sclkLast;
  logic ssLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      ssPipe   <= '1;
      mosiPipe <= '0;
      sclkLast <= 1'b0;
      ssLast   <= 1'b1;
    end else begin
      sclkPipe <= {sclkPipe[STAGES-2:0], sclk};
      ssPipe   <= {ssPipe[STAGES-2:0], ssN};
      mosiPipe <= {mosiPipe[STAGES-2:0], mosi};
      sclkLast <= sclkPipe[STAGES-1];
      ssLast   <= ssPipe[STAGES-1];
    end
  end

  assign sclkRise = sclkPipe[STAGES-1] & ~sclkLast;
  assign sclkFall = ~sclkPipe[STAGES-1] & sclkLast;
  assign ssFall   = ~ssPipe[STAGES-1] & ssLast;
  assign ssRise   = ssPipe[STAGES-1] & ~ssLast;
  assign mosiS    = mosiPipe[STAGES-1];

endmodule

// File: rtl/spi_target_ctrl.sv
module spi_target_ctrl
  import spi_target_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int SHORT_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclkRise,
  input  logic        sclkFall,
  input  logic        ssFall,
  input  logic        ssRise,
  input  logic        cpol,
  input  logic        cpha,
  input  logic        wide16,
  input  logic        hostCsN,
  input  logic        hostWr,
  input  logic        hostRd,
  output ctlStrobes_t str,
  output logic        selActive,
  output logic        txReady,
  output logic        rxReady,
  output logic        rxError,
  output logic        txError,
  output logic        txAck,
  output logic        txNack
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_W - 1);

  frameState_e state;
  logic [CNT_W-1:0] bitCnt;
  logic firstLead;
  logic fromHost;
  logic txFull;

  logic leadEv, trailEv, sampleEv, shiftEv, lastBit, wrHit, rdHit;

  always_comb begin
    leadEv   = cpol ? sclkFall : sclkRise;
    trailEv  = cpol ? sclkRise : sclkFall;
    sampleEv = cpha ? trailEv : leadEv;
    shiftEv  = cpha ? leadEv : trailEv;
    lastBit  = (bitCnt == (wide16 ? LAST_LONG : LAST_SHORT));
    wrHit    = ~hostCsN & hostWr;
    rdHit    = ~hostCsN & hostRd;

    str           = '0;
    str.writeHold = wrHit;
    str.loadTx    = (state == ST_IDLE) && ssFall;
    if (state == ST_SHIFT && !ssRise) begin
      str.sampleRx = sampleEv;
      str.shiftTx  = shiftEv && !(cpha && firstLead);
      str.commitRx = sampleEv && lastBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      firstLead <= 1'b1;
      fromHost  <= 1'b0;
      txFull    <= 1'b0;
      rxReady   <= 1'b0;
      rxError   <= 1'b0;
      txError   <= 1'b0;
      txAck     <= 1'b0;
      txNack    <= 1'b0;
    end else begin
      rxError <= 1'b0;
      txError <= 1'b0;
      txAck   <= 1'b0;
      txNack  <= 1'b0;

      if (wrHit)           txFull <= 1'b1;
      else if (str.loadTx) txFull <= 1'b0;

      if (str.commitRx)    rxReady <= 1'b1;
      else if (rdHit)      rxReady <= 1'b0;

      unique case (state)
        ST_IDLE: begin
          if (ssFall) begin
            state     <= ST_SHIFT;
            bitCnt    <= '0;
            firstLead <= 1'b1;
            fromHost  <= txFull;
            txError   <= ~txFull;
          end
        end
        ST_SHIFT: begin
          if (ssRise) begin
            state  <= ST_IDLE;
            txNack <= 1'b1;
          end else begin
            if (leadEv) firstLead <= 1'b0;
            if (sampleEv) begin
              if (lastBit) begin
                state   <= ST_DONE;
                txAck   <= fromHost;
                rxError <= rxReady & ~rdHit;
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
          end
        end
        ST_DONE: begin
          if (ssRise) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign selActive = (state != ST_IDLE);
  assign txReady   = ~txFull;

endmodule

// File: rtl/spi_target_datapath.sv
module spi_target_datapath
  import spi_target_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       str,
  input  logic              selActive,
  input  logic              lsbFirst,
  input  logic              wide16,
  input  logic              mosiS,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  output logic              miso
);

  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] rxNext;
  logic [DATA_W-1:0] rxHold;
  logic              outBit;

  // Next receive shifter value for each bit order and width
  always_comb begin
    if (!lsbFirst) begin
      rxNext = {rxShift[DATA_W-2:0], mosiS};
    end else begin
      rxNext = rxShift >> 1;
      if (wide16) rxNext[DATA_W-1]  = mosiS;
      else        rxNext[SHORT_W-1] = mosiS;
    end
  end

  always_comb begin
    if (lsbFirst)    outBit = txShift[0];
    else if (wide16) outBit = txShift[DATA_W-1];
    else             outBit = txShift[SHORT_W-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= '0;
      txShift <= '0;
      rxShift <= '0;
      rxHold  <= '0;
    end else begin
      if (str.writeHold) holdReg <= hostWrData;

      if (str.loadTx) begin
        txShift <= holdReg;
        rxShift <= '0;
      end else begin
        if (str.shiftTx) txShift <= lsbFirst ? (txShift >> 1) : (txShift << 1);
        if (str.sampleRx) rxShift <= rxNext;
      end

      if (str.commitRx) begin
        rxHold <= wide16 ? rxNext
                         : {{(DATA_W-SHORT_W){1'b0}}, rxNext[SHORT_W-1:0]};
      end
    end
  end

  assign miso       = selActive & outBit;
  assign hostRdData = rxHold;

endmodule

// File: rtl/spi_target_port.sv
module spi_target_port
  import spi_target_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SHORT_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              ssN,
  input  logic              mosi,
  output logic              miso,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsbFirst,
  input  logic              wide16,
  input  logic              hostCsN,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  output logic              txReady,
  output logic              rxReady,
  output logic              rxError,
  output logic              txError,
  output logic              txAck,
  output logic              txNack
);

  logic sclkRise, sclkFall, ssFall, ssRise, mosiS, selActive;
  ctlStrobes_t str;

  spi_target_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclk(sclk), .ssN(ssN), .mosi(mosi),
    .sclkRise(sclkRise), .sclkFall(sclkFall),
    .ssFall(ssFall), .ssRise(ssRise), .mosiS(mosiS)
  );

  spi_target_ctrl #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .sclkRise(sclkRise), .sclkFall(sclkFall),
    .ssFall(ssFall), .ssRise(ssRise),
    .cpol(cpol), .cpha(cpha), .wide16(wide16),
    .hostCsN(hostCsN), .hostWr(hostWr), .hostRd(hostRd),
    .str(str), .selActive(selActive),
    .txReady(txReady), .rxReady(rxReady),
    .rxError(rxError), .txError(txError),
    .txAck(txAck), .txNack(txNack)
  );

  spi_target_datapath #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .selActive(selActive),
    .lsbFirst(lsbFirst), .wide16(wide16), .mosiS(mosiS),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .miso(miso)
  );

endmodule

// File: rtl/spi_target_port_chk.sv
module spi_target_port_chk (
  input logic clk,
  input logic rstN,
  input logic ssN,
  input logic hostCsN,
  input logic hostWr,
  input logic hostRd,
  input logic miso,
  input logic txReady,
  input logic rxReady,
  input logic rxError,
  input logic txError,
  input logic txAck,
  input logic txNack
);

  assert_ack_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    txAck |=> !txAck);

  assert_nack_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    txNack |=> !txNack);

  assert_ack_nack_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(txAck && txNack));

  assert_rx_clear_by_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxReady) |-> $past(!hostCsN && hostRd));

  assert_tx_fill_by_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txReady) |-> $past(!hostCsN && hostWr));

  assert_overrun_R7: assert property (@(posedge clk) disable iff (!rstN)
    rxError |-> ($past(rxReady) && rxReady));

  assert_underrun_R8: assert property (@(posedge clk) disable iff (!rstN)
    txError |-> $past(txReady));

  assert_idle_miso_R11: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ssN, 1) && $past(ssN, 2) && $past(ssN, 3) && $past(ssN, 4)) |-> !miso);

endmodule

bind spi_target_port spi_target_port_chk u_chk (
  .clk(clk), .rstN(rstN), .ssN(ssN),
  .hostCsN(hostCsN), .hostWr(hostWr), .hostRd(hostRd),
  .miso(miso), .txReady(txReady), .rxReady(rxReady),
  .rxError(rxError), .txError(txError), .txAck(txAck), .txNack(txNack)
);

// File: tb/spi_target_port_bench.sv
module spi_target_port_bench;

  localparam int HALF = 8;  // system clocks per serial half period

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0, ssN = 1'b1, mosi = 1'b0;
  logic cpol = 1'b0, cpha = 1'b0, lsbFirst = 1'b0, wide16 = 1'b1;
  logic wrReq = 1'b0, rdReq = 1'b0, csBlock = 1'b0, rawWr = 1'b0;
  logic [15:0] hostWrData = '0;
  logic miso, txReady, rxReady, rxError, txError, txAck, txNack;
  logic [15:0] hostRdData;
  logic hostCsN;

  assign hostCsN = csBlock | ~(wrReq | rdReq | rawWr);

  spi_target_port u_spi_target_port (
    .clk(clk), .rstN(rstN), .sclk(sclk), .ssN(ssN), .mosi(mosi), .miso(miso),
    .cpol(cpol), .cpha(cpha), .lsbFirst(lsbFirst), .wide16(wide16),
    .hostCsN(hostCsN), .hostWr(wrReq | rawWr), .hostRd(rdReq),
    .hostWrData(hostWrData), .hostRdData(hostRdData),
    .txReady(txReady), .rxReady(rxReady), .rxError(rxError),
    .txError(txError), .txAck(txAck), .txNack(txNack)
  );

  always #2.5 clk = ~clk;  // 200 MHz

  int checks = 0, errors = 0;
  int ackCnt = 0, nackCnt = 0, txErrCnt = 0, rxErrCnt = 0;
  bit monOn = 1'b1;
  bit finished = 1'b0;
  logic [15:0] rxQueue[$];
  logic [15:0] lastWr = '0;

  always @(negedge clk) begin
    if (txAck)   ackCnt++;
    if (txNack)  nackCnt++;
    if (txError) txErrCnt++;
    if (rxError) rxErrCnt++;
  end

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hostWrite(input logic [15:0] w);
    @(negedge clk);
    hostWrData = w;
    wrReq = 1'b1;
    @(negedge clk);
    wrReq = 1'b0;
    lastWr = w;
  endtask

  // Serial master model; abortAt < width stops the frame early
  task automatic spiFrame(input logic [15:0] send, input int abortAt,
                          output logic [15:0] got);
    int w;
    w = wide16 ? 16 : 8;
    got = '0;
    @(negedge clk);
    sclk = cpol;
    if (!cpha) mosi = send[lsbFirst ? 0 : w-1];
    waitClk(1);
    ssN = 1'b0;
    waitClk(HALF);
    for (int i = 0; i < w; i++) begin
      int idx;
      if (i == abortAt) break;
      idx = lsbFirst ? i : w-1-i;
      if (cpha) mosi = send[idx];
      else      got[idx] = miso;
      sclk = ~cpol;
      waitClk(HALF);
      if (cpha) got[idx] = miso;
      else if (i < w-1) mosi = send[lsbFirst ? i+1 : w-2-i];
      sclk = cpol;
      waitClk(HALF);
    end
    ssN = 1'b1;
    waitClk(2*HALF);
  endtask

  // Scoreboard monitor: read each received word and compare with the queue
  initial begin
    forever begin
      @(negedge clk);
      if (monOn && rxReady && !rdReq) begin
        if (rxQueue.size() == 0) begin
          checks++; errors++;
          $display("FAIL R6: unexpected word %h, expected none", hostRdData);
        end else begin
          chk("R6 received word", hostRdData, rxQueue.pop_front());
        end
        rdReq = 1'b1;
        @(negedge clk);
        rdReq = 1'b0;
      end
    end
  end

  task automatic fullFrame(input string req, input logic [15:0] txw,
                           input logic [15:0] rxw);
    logic [15:0] got;
    logic [15:0] mask;
    int ackBefore;
    mask = wide16 ? 16'hFFFF : 16'h00FF;
    hostWrite(txw);
    chk({req, " R5 txReady low after write"}, {15'b0, txReady}, 16'h0);
    rxQueue.push_back(rxw & mask);
    ackBefore = ackCnt;
    spiFrame(rxw, 99, got);
    waitClk(4);
    chk({req, " miso word"}, got, txw & mask);
    chk({req, " R9 txAck count"}, 16'(ackCnt - ackBefore), 16'd1);
    chk({req, " R5 txReady back"}, {15'b0, txReady}, 16'h1);
  endtask

  initial begin
    logic [15:0] got;
    int accB, nB, eB;
    waitClk(5);
    rstN = 1'b1;
    waitClk(2);
    // R1 reset state
    chk("R1 txReady", {15'b0, txReady}, 16'h1);
    chk("R1 rxReady", {15'b0, rxReady}, 16'h0);
    chk("R1 miso", {15'b0, miso}, 16'h0);
    chk("R1 pulses", {12'b0, rxError, txError, txAck, txNack}, 16'h0);

    // R2: all four modes, MSB first, 16 bits
    for (int m = 0; m < 4; m++) begin
      cpol = m[1]; cpha = m[0];
      fullFrame("R2 mode", 16'hA35C ^ 16'(m * 16'h1111), 16'h5AC3 + 16'(m));
    end
    // R3: LSB first in two modes
    lsbFirst = 1'b1;
    cpol = 1'b0; cpha = 1'b0;
    fullFrame("R3 lsb mode0", 16'h8001, 16'h0F31);
    cpol = 1'b1; cpha = 1'b1;
    fullFrame("R3 lsb mode3", 16'h1E2D, 16'hC006);
    // R4: 8-bit frames, both orders
    wide16 = 1'b0;
    fullFrame("R4 byte lsb", 16'hBEEF, 16'hFF96);
    lsbFirst = 1'b0; cpol = 1'b0; cpha = 1'b1;
    fullFrame("R4 byte msb", 16'h12C4, 16'h00A7);
    wide16 = 1'b1;
    waitClk(10);
    chk("R6 scoreboard drained", 16'(rxQueue.size()), 16'd0);

    // R8 underrun: no write, last written word is sent again
    accB = ackCnt; eB = txErrCnt;
    rxQueue.push_back(16'h3C3C);
    spiFrame(16'h3C3C, 99, got);
    waitClk(4);
    chk("R8 txError count", 16'(txErrCnt - eB), 16'd1);
    chk("R8 repeated word", got, lastWr);
    chk("R9 no ack on underrun", 16'(ackCnt - accB), 16'd0);

    // R7 overrun: host does not read between two frames
    monOn = 1'b0;
    waitClk(10);
    eB = rxErrCnt;
    hostWrite(16'h1357);
    spiFrame(16'h1111, 99, got);
    hostWrite(16'h2468);
    spiFrame(16'h2222, 99, got);
    waitClk(4);
    chk("R7 rxError count", 16'(rxErrCnt - eB), 16'd1);
    chk("R7 rxReady held", {15'b0, rxReady}, 16'h1);
    chk("R7 newest word kept", hostRdData, 16'h2222);
    @(negedge clk); rdReq = 1'b1;
    @(negedge clk); rdReq = 1'b0;
    chk("R6 read clears rxReady", {15'b0, rxReady}, 16'h0);
    monOn = 1'b1;

    // R10 abort after five bits
    accB = ackCnt; nB = nackCnt;
    hostWrite(16'h7E81);
    spiFrame(16'h4D4D, 5, got);
    waitClk(4);
    chk("R10 txNack count", 16'(nackCnt - nB), 16'd1);
    chk("R10 no ack", 16'(ackCnt - accB), 16'd0);
    chk("R10 rxReady unchanged", {15'b0, rxReady}, 16'h0);
    chk("R10 rx word unchanged", hostRdData, 16'h2222);
    chk("R10 txReady after consume", {15'b0, txReady}, 16'h1);

    // R11 serial clock without select, host write with chip select high
    for (int k = 0; k < 20; k++) begin
      sclk = ~sclk; mosi = k[0];
      waitClk(HALF);
      if (miso !== 1'b0) chk("R11 miso idle", {15'b0, miso}, 16'h0);
    end
    sclk = cpol;
    waitClk(10);
    chk("R11 rxReady unaffected", {15'b0, rxReady}, 16'h0);
    chk("R11 miso idle", {15'b0, miso}, 16'h0);
    @(negedge clk); csBlock = 1'b1; hostWrData = 16'hDEAD; rawWr = 1'b1;
    @(negedge clk); rawWr = 1'b0; csBlock = 1'b0;
    waitClk(2);
    chk("R11 write ignored", {15'b0, txReady}, 16'h1);

    // Back to normal after the corner cases
    cpol = 1'b1; cpha = 1'b0;
    fullFrame("R2 mode2 recovery", 16'h6B19, 16'h90F2);
    waitClk(10);
    chk("R6 scoreboard empty", 16'(rxQueue.size()), 16'd0);

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule